// File: doc/BRIEF.md
# Conversion Result Holding Register with Paired-Byte Read Lock

This block keeps the most recent 10-bit conversion result and lets a byte-wide register bus read it as two bytes, low and high. A result word comes in from the converter with a one-cycle valid strobe. The bus supplies a justification select and one read strobe per byte, and the block returns the addressed byte on the same cycle, combinationally. Code 0x000 stands for ground and 0x3FF stands for the reference minus one LSB.

The two bytes of a result must always belong together. Reading the low byte therefore freezes the register until the high byte is read. A result that arrives during that window is parked in a one-deep buffer, and a newer arrival overwrites it. The parked result is loaded when the high-byte read releases the lock. Reading the high byte on its own never locks the register, so software that needs only 8 bits can poll the high byte in left-justified form.

Justification is not stored with the result. It is applied to the stored word each time a read happens, so a change of the select shows in the very next read.

Top module: `adc_result_hold`

## Requirements
- R1: After reset, the held result is zero, so both bytes read 0x00 under either justification.
- R2: With `just_left`=0 (right justified), the high byte carries result bits 9:8 in its bits 1:0 with bits 7:2 zero, and the low byte carries result bits 7:0.
- R3: With `just_left`=1 (left justified), the high byte carries result bits 9:2, and the low byte carries result bits 1:0 in its bits 7:6 with bits 5:0 zero.
- R4: A change of `just_left` changes the byte being read in the same cycle, with no clock edge needed.
- R5: A cycle with `rd_lo` high locks the register. While it is locked, no `res_valid` pulse changes the held result until a cycle with `rd_hi` high.
- R6: A cycle with `rd_hi` high while the register is unlocked does not lock it, so a following result replaces the held value.
- R7: A result that arrives while the register is locked is loaded on the edge that ends the releasing high-byte read cycle. When several arrive, only the latest is kept.
- R8: When `res_valid` and a releasing `rd_hi` fall in the same cycle, that read returns the old result, and the new result is readable from the next cycle.
- R9: When neither read strobe is high, `rd_data` is 0x00.
- R10: With the register unlocked, a `res_valid` pulse makes its result readable from the following cycle.
- R11: A `res_valid` pulse in the same cycle as a low-byte read does not replace the held result. The high byte read afterwards belongs to the same result as that low byte, and the new result is loaded at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_data | input | 10 | Conversion result word |
| res_valid | input | 1 | One-cycle strobe qualifying `res_data` |
| just_left | input | 1 | 1 = left justified view, 0 = right justified |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Byte returned for the active read strobe |

## Verification
The assertions assume that the bus never raises `rd_lo` and `rd_hi` in the same cycle, because a real register bus addresses only one byte per access. The bench drives each read strobe in a cycle of its own, and it raises `res_valid` together with a read strobe only in the cycles that test R8 and R11. All strobes are driven on the falling clock edge and released one cycle later, so each is exactly one cycle long.

// File: rtl/ahr_pkg.sv
// Shared types for the result holding register.
// Assumes: nothing beyond a single clock domain.
package ahr_pkg;

    // What the holding register loads on the next edge.
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_NEW  = 2'd1,
        LD_PEND = 2'd2
    } ld_sel_e;

endpackage

// File: rtl/ahr_lock_ctrl.sv
// Lock and release sequencing for the paired-byte read.
// It decides when the holding register loads, when an arrival is parked,
// and tracks the lock and pending flags.
// Assumes: rd_lo and rd_hi are never high in the same cycle.
module ahr_lock_ctrl
    import ahr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    res_valid,
    input  logic    rd_lo,
    input  logic    rd_hi,
    output ld_sel_e ld_sel,
    output logic    park,
    output logic    locked
);

    logic pend_v;
    logic release_now;

    // A high-byte read that ends a locked window.
    assign release_now = locked & rd_hi & ~rd_lo;

    // Choose the source for the holding register and whether to park.
    always_comb begin
        ld_sel = LD_NONE;
        park   = 1'b0;
        if (res_valid && !rd_lo && (!locked || release_now)) begin
            ld_sel = LD_NEW;
        end else if (release_now && pend_v) begin
            ld_sel = LD_PEND;
        end
        if (res_valid && (rd_lo || (locked && !release_now))) begin
            park = 1'b1;
        end
    end

    // Lock flag: set by a low read, cleared by a high read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (rd_lo) begin
            locked <= 1'b1;
        end else if (rd_hi) begin
            locked <= 1'b0;
        end
    end

    // Pending flag: set on park, dropped when the lock is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
        end else if (park) begin
            pend_v <= 1'b1;
        end else if (release_now) begin
            pend_v <= 1'b0;
        end
    end

endmodule

// File: rtl/ahr_store.sv
// Storage for the held result and the one-deep pending slot.
// Assumes: ld_sel and park come from ahr_lock_ctrl.
module ahr_store
    import ahr_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_data,
    input  ld_sel_e          ld_sel,
    input  logic             park,
    output logic [RES_W-1:0] hold
);

    logic [RES_W-1:0] pend_q;

    // Holding register: loads a fresh or a parked result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else begin
            unique case (ld_sel)
                LD_NEW:  hold <= res_data;
                LD_PEND: hold <= pend_q;
                default: hold <= hold;
            endcase
        end
    end

    // Pending slot: the latest arrival during a lock overwrites it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (park) begin
            pend_q <= res_data;
        end
    end

endmodule

// File: rtl/ahr_justify.sv
// Read-time justification and byte selection.
// Assumes: BYTE_W < RES_W <= 2*BYTE_W; at most one read strobe at a time.
module ahr_justify #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  hold,
    input  logic              just_left,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD    = WORD_W - RES_W;

    logic [WORD_W-1:0] word_r;
    logic [WORD_W-1:0] word_l;
    logic [WORD_W-1:0] word;

    // Build the two justified views of the held result.
    generate
        if (PAD > 0) begin : g_pad
            assign word_r = {{PAD{1'b0}}, hold};
            assign word_l = {hold, {PAD{1'b0}}};
        end else begin : g_nopad
            assign word_r = hold;
            assign word_l = hold;
        end
    endgenerate

    assign word = just_left ? word_l : word_r;

    // Return the addressed byte, zero when idle.
    always_comb begin
        if (rd_lo) begin
            rd_data = word[BYTE_W-1:0];
        end else if (rd_hi) begin
            rd_data = word[WORD_W-1:BYTE_W];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/adc_result_hold.sv
// Conversion result holding register with a low-then-high read lock.
// Connects sequencing, storage and read-time justification.
// Assumes: synchronous active-low reset; rd_lo and rd_hi exclusive.
module adc_result_hold
    import ahr_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_valid,
    input  logic              just_left,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data
);

    ld_sel_e          ld_sel;
    logic             park;
    logic             lock_q;
    logic [RES_W-1:0] hold_q;

    ahr_lock_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .ld_sel    (ld_sel),
        .park      (park),
        .locked    (lock_q)
    );

    ahr_store #(.RES_W(RES_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_data (res_data),
        .ld_sel   (ld_sel),
        .park     (park),
        .hold     (hold_q)
    );

    ahr_justify #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_just (
        .hold      (hold_q),
        .just_left (just_left),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/ahr_checker.sv
// Property checks for adc_result_hold, attached with bind.
// Assumes: rd_lo and rd_hi are never high together.
module ahr_checker #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RES_W-1:0]  res_data,
    input logic              res_valid,
    input logic              just_left,
    input logic              rd_lo,
    input logic              rd_hi,
    input logic [BYTE_W-1:0] rd_data,
    input logic              locked,
    input logic [RES_W-1:0]  hold
);

    localparam int PAD = 2 * BYTE_W - RES_W;

    AST_RIGHT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !just_left) |-> rd_data[BYTE_W-1:BYTE_W-PAD] == '0); // R2
    AST_LEFT_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && just_left) |-> rd_data[PAD-1:0] == '0); // R3
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rd_hi) |=> $stable(hold)); // R5
    AST_LO_READ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> locked); // R5
    AST_HI_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && rd_hi && !rd_lo) |=> !locked); // R6
    AST_RELEASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && rd_hi && !rd_lo && res_valid) |=> hold == $past(res_data)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && !rd_hi) |-> rd_data == '0); // R9
    AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && res_valid && !rd_lo) |=> hold == $past(res_data)); // R10
    AST_NO_TEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && rd_lo) |=> $stable(hold)); // R11

endmodule

bind adc_result_hold ahr_checker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_data  (res_data),
    .res_valid (res_valid),
    .just_left (just_left),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .rd_data   (rd_data),
    .locked    (lock_q),
    .hold      (hold_q)
);

// File: tb/sim_adc_result_hold.sv
module sim_adc_result_hold;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] res_data = '0;
    logic       res_valid = 1'b0;
    logic       just_left = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    adc_result_hold u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_data  (res_data),
        .res_valid (res_valid),
        .just_left (just_left),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .rd_data   (rd_data)
    );

    // Vector: result, justification, expected high byte, expected low byte.
    typedef struct packed {
        logic [9:0] res;
        logic       left;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h3FF, 1'b0, 8'h03, 8'hFF},
        '{10'h3FF, 1'b1, 8'hFF, 8'hC0},
        '{10'h2A5, 1'b0, 8'h02, 8'hA5},
        '{10'h2A5, 1'b1, 8'hA9, 8'h40},
        '{10'h15A, 1'b0, 8'h01, 8'h5A},
        '{10'h15A, 1'b1, 8'h56, 8'h80},
        '{10'h001, 1'b1, 8'h00, 8'h40},
        '{10'h200, 1'b0, 8'h02, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One-cycle result pulse.
    task automatic push(input logic [9:0] r);
        @(negedge clk);
        res_data = r; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // One-cycle read of the low (hi_sel=0) or high byte, checked mid-cycle.
    task automatic rd(input logic hi_sel, input string req, input logic [7:0] exp);
        @(negedge clk);
        rd_lo = ~hi_sel; rd_hi = hi_sel;
        #1 check(req, rd_data, exp);
        @(negedge clk);
        rd_lo = 1'b0; rd_hi = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value under both views
        rd(1'b0, "R1 lo right", 8'h00);
        rd(1'b1, "R1 hi right", 8'h00);
        just_left = 1'b1;
        rd(1'b0, "R1 lo left", 8'h00);
        rd(1'b1, "R1 hi left", 8'h00);

        // R2 R3 R10: vector walk
        foreach (VECS[i]) begin
            push(VECS[i].res);
            just_left = VECS[i].left;
            rd(1'b0, VECS[i].left ? "R3 lo" : "R2 lo", VECS[i].lo);
            rd(1'b1, VECS[i].left ? "R3 hi" : "R10 hi", VECS[i].hi);
        end

        // R9: idle bus reads zero
        @(negedge clk);
        #1 check("R9 idle", rd_data, 8'h00);

        // R4: live justification inside one read cycle
        push(10'h2A5);
        @(negedge clk);
        just_left = 1'b0; rd_hi = 1'b1;
        #1 check("R4 right", rd_data, 8'h02);
        just_left = 1'b1;
        #1 check("R4 left", rd_data, 8'hA9);
        @(negedge clk);
        rd_hi = 1'b0; just_left = 1'b0;

        // R5 R7: arrival during lock waits, then loads at release
        push(10'h111);
        rd(1'b0, "R5 lo", 8'h11);
        push(10'h222);
        rd(1'b1, "R5 hi frozen", 8'h01);
        rd(1'b0, "R7 pending lo", 8'h22);
        rd(1'b1, "R7 pending hi", 8'h02);

        // R7: latest arrival replaces pending one
        rd(1'b0, "R7 lock", 8'h22);
        push(10'h0F0);
        push(10'h30C);
        rd(1'b1, "R7 hi old", 8'h02);
        rd(1'b0, "R7 latest lo", 8'h0C);
        rd(1'b1, "R7 latest hi", 8'h03);

        // R6: high-only polling sees every new result
        just_left = 1'b1;
        push(10'h155);
        rd(1'b1, "R6 hi first", 8'h55);
        push(10'h3A8);
        rd(1'b1, "R6 hi second", 8'hEA);
        just_left = 1'b0;

        // R8: result with releasing high read
        rd(1'b0, "R8 lock", 8'hA8);
        @(negedge clk);
        rd_hi = 1'b1; res_data = 10'h0AB; res_valid = 1'b1;
        #1 check("R8 hi old", rd_data, 8'h03);
        @(negedge clk);
        rd_hi = 1'b0; res_valid = 1'b0;
        rd(1'b0, "R8 new lo", 8'hAB);
        rd(1'b1, "R8 new hi", 8'h00);

        // R11: result with low read while unlocked
        push(10'h1C3);
        @(negedge clk);
        rd_lo = 1'b1; res_data = 10'h2E7; res_valid = 1'b1;
        #1 check("R11 lo old", rd_data, 8'hC3);
        @(negedge clk);
        rd_lo = 1'b0; res_valid = 1'b0;
        rd(1'b1, "R11 hi same", 8'h01);
        rd(1'b0, "R11 new lo", 8'hE7);
        rd(1'b1, "R11 new hi", 8'h02);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule